// File: doc/BRIEF.md
# Serial Engine Command Processor

This block interprets a stream of byte-coded commands arriving over a valid/ready data path. Some commands carry one or two operand bytes. The commands set two groups of eight general-purpose pins (level and direction) and read them back. They also control a serial clock generator: they set its divisor and an optional divide-by-five prescale, and they can run bursts of clock pulses that move no data. The remaining commands stall parsing until an external pin reaches a level, loop the data-out line back onto the data-in pin, request a flush from the upstream buffer, and switch the pins to open-collector drive.

Bytes read back from the pins, and error reports for opcodes the block does not know, leave on a response stream that has a one-cycle valid. In the low pin group, bit 0 is the serial clock, bit 1 is data-out and bit 2 is data-in. The level written to bit 0 is the level the clock rests at between pulses.

Top module: `serial_cmd_engine`

## Requirements
- R1: After reset, `pin_out`, `pin_oe`, `sclk` and `sdo` are all zero, no response and no flush are issued, and `cmd_ready` is high.
- R2: Opcode 0x80 followed by bytes V then D sets `pin_out[7:0]` to V and `pin_oe[7:0]` to D, where 1 means drive. Opcode 0x82 does the same for bits 15:8. Bit 0 of V is the idle level of `sclk`, and bit 1 of V drives `sdo`.
- R3: Opcode 0x81 puts one response byte holding `pin_in[7:0]` on the stream in the cycle after the opcode is accepted. Opcode 0x83 does the same with `pin_in[15:8]`.
- R4: After opcode 0x84, bit 2 of a low-group read returns the `sdo` level instead of `pin_in[2]`. Opcode 0x85 restores the pin.
- R5: Opcode 0x86 followed by bytes L then H sets the divisor D = {H,L}. Each clock pulse is active for (D+1) cycles, or for 5*(D+1) cycles after opcode 0x8B. Opcode 0x8A cancels the ×5.
- R6: Opcode 0x87 raises `flush` for exactly one cycle, the cycle after it is accepted. No other opcode raises `flush`.
- R7: Opcode 0x88 holds `cmd_ready` low until `wait_pin` is 1. Opcode 0x89 holds it low until `wait_pin` is 0. Parsing then resumes.
- R8: Opcode 0x8E followed by byte N gives N+1 clock pulses. Opcode 0x8F followed by bytes L then H gives ({H,L}+1)*8 pulses. `cmd_ready` stays low for the whole burst, and `sclk` returns to its idle level afterwards.
- R9: Opcodes 0x94 and 0x95 give pulses until `wait_pin` is 1 or 0 respectively. The pin is tested before each pulse starts, so a pin that is already at the level gives zero pulses.
- R10: Opcodes 0x9C and 0x9D, each followed by bytes L then H, stop at whichever comes first: ({H,L}+1)*8 pulses, or the 0x94 or 0x95 pin condition respectively.
- R11: After opcode 0x9E, a pin is driven only while its direction is 1 and its level is 0.
- R12: Any other opcode gives the response bytes 0xFA and then the opcode, in two consecutive cycles. It changes no pin state, and the next byte is parsed as an opcode.
- R13: `sclk` changes only during a clock burst or when the low group is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the base of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_data | input | 8 | Command or operand byte |
| cmd_valid | input | 1 | `cmd_data` holds a byte |
| cmd_ready | output | 1 | Byte accepted on this edge when valid |
| pin_in | input | 16 | Sampled pin levels, high group in 15:8 |
| wait_pin | input | 1 | Pin tested by wait and conditional-clock commands |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin drive enables |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data-out line |
| rsp_valid | output | 1 | Response byte present for this cycle |
| rsp_data | output | 8 | Response byte |
| flush | output | 1 | One-cycle flush request |

## Verification
The bench tests pin writes and reads with several level, direction and input patterns, so that bit-swaps and mixed-up groups show up. It sweeps the divisor and the ×5 setting, counting both the pulses and the active cycles, which separates a wrong pulse count from a wrong pulse width. The pin-conditioned bursts run with the pin already at its level, with the pin changing partway through, and with the pin never changing. These cases separate testing before each pulse from testing elsewhere, and show which limit ends a burst. Every opcode outside the command set is sent once, and the bench checks that each gives the two-byte error report and leaves the pin state unchanged.

// File: rtl/serial_cmd_engine.sv
module serial_cmd_engine #(
  parameter int SLOW_DIV = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cmd_data,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] pin_in,
  input  logic        wait_pin,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe,
  output logic        sclk,
  output logic        sdo,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        flush
);
  localparam int DIV_W  = 16;
  localparam int HALF_W = DIV_W + 3;
  localparam int CNT_W  = DIV_W + 4;

  typedef enum logic [2:0] {S_OP, S_ARG, S_WAIT, S_CLK, S_ERR} st_t;

  st_t               st;
  logic [7:0]        op, a0, lo_val, lo_dir, hi_val, hi_dir;
  logic              argi, loop_en, div5, oc, wlvl, use_cnt, use_cond, act;
  logic [DIV_W-1:0]  div;
  logic [CNT_W-1:0]  left;
  logic [HALF_W-1:0] hc, half_len;

  function automatic logic [1:0] nargs(input logic [7:0] o);
    case (o)
      8'h80, 8'h82, 8'h86, 8'h8F, 8'h9C, 8'h9D: nargs = 2'd2;
      8'h8E:                                    nargs = 2'd1;
      default:                                  nargs = 2'd0;
    endcase
  endfunction

  assign cmd_ready = (st == S_OP) || (st == S_ARG);
  wire        acc      = cmd_valid && cmd_ready;
  wire [7:0]  eop      = (st == S_OP) ? cmd_data : op;
  wire [7:0]  ea0      = (st == S_ARG && nargs(op) == 2'd1) ? cmd_data : a0;
  wire [7:0]  ea1      = cmd_data;
  wire        go       = acc && ((st == S_OP && nargs(cmd_data) == 2'd0) ||
                                 (st == S_ARG && (nargs(op) == 2'd1 || argi)));
  wire        cond_met = (wait_pin == wlvl);
  wire [CNT_W-1:0] byte_pulses = (CNT_W'({ea1, ea0}) + CNT_W'(1)) << 3;

  assign half_len = div5 ? (HALF_W'(div) + HALF_W'(1)) * HALF_W'(SLOW_DIV)
                         : HALF_W'(div) + HALF_W'(1);

  assign sclk    = lo_val[0] ^ act;
  assign sdo     = lo_val[1];
  assign pin_out = {hi_val, lo_val[7:2], sdo, sclk};
  assign pin_oe  = oc ? ({hi_dir, lo_dir} & ~pin_out) : {hi_dir, lo_dir};
  wire [7:0] rd_lo = {pin_in[7:3], loop_en ? sdo : pin_in[2], pin_in[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; op <= '0; a0 <= '0; argi <= 1'b0;
      lo_val <= '0; lo_dir <= '0; hi_val <= '0; hi_dir <= '0;
      loop_en <= 1'b0; div5 <= 1'b0; oc <= 1'b0; wlvl <= 1'b0;
      use_cnt <= 1'b0; use_cond <= 1'b0; act <= 1'b0;
      div <= '0; left <= '0; hc <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0; flush <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      flush     <= 1'b0;
      case (st)
        S_OP: if (acc) begin
          op <= cmd_data;
          argi <= 1'b0;
          if (nargs(cmd_data) != 2'd0) st <= S_ARG;
        end
        S_ARG: if (acc) begin
          a0 <= cmd_data;
          argi <= 1'b1;
          if (go) st <= S_OP;
        end
        S_WAIT: if (cond_met) st <= S_OP;
        S_CLK:
          if (hc != '0) hc <= hc - HALF_W'(1);
          else if (act) begin
            act <= 1'b0;
            hc  <= half_len - HALF_W'(1);
          end else if ((use_cnt && left == '0) || (use_cond && cond_met)) st <= S_OP;
          else begin
            act <= 1'b1;
            hc  <= half_len - HALF_W'(1);
            if (use_cnt) left <= left - CNT_W'(1);
          end
        S_ERR: begin
          rsp_valid <= 1'b1;
          rsp_data  <= op;
          st        <= S_OP;
        end
        default: st <= S_OP;
      endcase

      if (go) begin
        case (eop)
          8'h80: begin lo_val <= ea0; lo_dir <= ea1; end
          8'h82: begin hi_val <= ea0; hi_dir <= ea1; end
          8'h81: begin rsp_valid <= 1'b1; rsp_data <= rd_lo; end
          8'h83: begin rsp_valid <= 1'b1; rsp_data <= pin_in[15:8]; end
          8'h84: loop_en <= 1'b1;
          8'h85: loop_en <= 1'b0;
          8'h86: div <= {ea1, ea0};
          8'h87: flush <= 1'b1;
          8'h88: begin wlvl <= 1'b1; st <= S_WAIT; end
          8'h89: begin wlvl <= 1'b0; st <= S_WAIT; end
          8'h8A: div5 <= 1'b0;
          8'h8B: div5 <= 1'b1;
          8'h8E, 8'h8F, 8'h94, 8'h95, 8'h9C, 8'h9D: begin
            st <= S_CLK; hc <= '0; act <= 1'b0;
            use_cnt  <= (eop == 8'h8E) || (eop == 8'h8F) || (eop == 8'h9C) || (eop == 8'h9D);
            use_cond <= (eop == 8'h94) || (eop == 8'h95) || (eop == 8'h9C) || (eop == 8'h9D);
            wlvl     <= (eop == 8'h94) || (eop == 8'h9C);
            left     <= (eop == 8'h8E) ? CNT_W'(ea0) + CNT_W'(1) : byte_pulses;
          end
          8'h9E: oc <= 1'b1;
          default: begin rsp_valid <= 1'b1; rsp_data <= 8'hFA; st <= S_ERR; end
        endcase
      end
    end
  end

  AST_CLK_IDLE_PARSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (sclk == lo_val[0])); // R8
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(acc && st == S_OP && cmd_data == 8'h87)); // R6
  AST_OC_NO_HIGH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    oc |-> ((pin_oe & pin_out) == 16'h0)); // R11
  AST_ERR_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR) |-> (rsp_valid && rsp_data == 8'hFA)); // R12
  AST_SCLK_MOVES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> ($past(st) == S_CLK || $past(go))); // R13
endmodule

// File: tb/serial_cmd_engine_tb.sv
module serial_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_valid = 1'b0, wait_pin = 1'b0;
  logic [15:0] pin_in = '0;
  logic        cmd_ready, sclk, sdo, rsp_valid, flush;
  logic [15:0] pin_out, pin_oe;
  logic [7:0]  rsp_data;

  serial_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .pin_in(pin_in), .wait_pin(wait_pin),
    .pin_out(pin_out), .pin_oe(pin_oe), .sclk(sclk), .sdo(sdo),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flush(flush));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, rn = 0, fl = 0, pulses = 0, act_cyc = 0;
  logic [7:0] rq [0:15];
  logic idle_lvl = 1'b0, prev_sclk = 1'b0, finished = 1'b0;

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (rn < 16) rq[rn] = rsp_data;
      rn = rn + 1;
    end
    if (flush) fl = fl + 1;
    if (sclk != idle_lvl) begin
      act_cyc = act_cyc + 1;
      if (prev_sclk == idle_lvl) pulses = pulses + 1;
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    while (!cmd_ready) @(negedge clk);
    cmd_data = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    while (!cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clr();
    rn = 0; fl = 0; pulses = 0; act_cyc = 0;
  endtask

  function automatic bit known(input int o);
    case (o)
      'h80, 'h81, 'h82, 'h83, 'h84, 'h85, 'h86, 'h87, 'h88, 'h89, 'h8A, 'h8B,
      'h8E, 'h8F, 'h94, 'h95, 'h9C, 'h9D, 'h9E: known = 1'b1;
      default: known = 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pin_out == 0 && pin_oe == 0 && !sclk && !sdo, "R1", {pin_out, pin_oe}, 0);
    chk(!rsp_valid && !flush && cmd_ready, "R1", {rsp_valid, flush, cmd_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 pin group writes
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v, d;
      v = 8'(i * 37 + 4); d = 8'(i * 91 + 3);
      send(8'h80); send(v); send(d);
      chk(pin_out[7:0] == v && pin_oe[7:0] == d, "R2 low", {pin_out[7:0], pin_oe[7:0]}, {v, d});
      chk(sclk == v[0] && sdo == v[1], "R2 clk/sdo", {sclk, sdo}, {v[0], v[1]});
      send(8'h82); send(~v); send(v ^ d);
      chk(pin_out[15:8] == ~v && pin_oe[15:8] == (v ^ d), "R2 high",
          {pin_out[15:8], pin_oe[15:8]}, {~v, v ^ d});
    end
    send(8'h80); send(8'h00); send(8'h03);
    settle();

    // R3 reads
    for (int i = 0; i < 6; i++) begin
      pin_in = 16'(i * 16'h2B3D + 16'h0101);
      clr();
      send(8'h81); send(8'h83);
      repeat (3) @(negedge clk);
      chk(rn == 2 && rq[0] == pin_in[7:0] && rq[1] == pin_in[15:8], "R3",
          {rq[0], rq[1]}, pin_in);
    end

    // R4 loopback
    pin_in = 16'h0000;
    send(8'h80); send(8'h02); send(8'h03);
    send(8'h84); settle(); clr();
    send(8'h81); repeat (2) @(negedge clk);
    chk(rn == 1 && rq[0] == 8'h04, "R4 on", rq[0], 8'h04);
    send(8'h85); settle(); clr();
    send(8'h81); repeat (2) @(negedge clk);
    chk(rn == 1 && rq[0] == 8'h00, "R4 off", rq[0], 8'h00);
    send(8'h80); send(8'h00); send(8'h03); settle();

    // R5 divisor and prescale, R8 burst length
    for (int dv = 0; dv < 4; dv++) begin
      for (int p = 0; p < 2; p++) begin
        send(8'h86); send(8'(dv)); send(8'h00);
        send(p ? 8'h8B : 8'h8A);
        settle(); clr();
        send(8'h8E); send(8'h02);
        settle();
        chk(pulses == 3 && act_cyc == 3 * (dv + 1) * (p ? 5 : 1), "R5",
            act_cyc, 3 * (dv + 1) * (p ? 5 : 1));
      end
    end
    send(8'h86); send(8'h00); send(8'h00); send(8'h8A); settle();

    for (int n = 0; n < 8; n++) begin
      clr(); send(8'h8E); send(8'(n)); settle();
      chk(pulses == n + 1 && sclk == idle_lvl, "R8 bits", pulses, n + 1);
    end
    for (int n = 0; n < 2; n++) begin
      clr(); send(8'h8F); send(8'(n)); send(8'h00); settle();
      chk(pulses == (n + 1) * 8, "R8 bytes", pulses, (n + 1) * 8);
    end
    idle_lvl = 1'b1;
    send(8'h80); send(8'h01); send(8'h03); settle();
    clr(); send(8'h8E); send(8'h04); settle();
    chk(pulses == 5 && sclk == 1'b1, "R8 idle high", pulses, 5);
    send(8'h80); send(8'h00); send(8'h03);
    idle_lvl = 1'b0;
    settle();

    // R9 wait-conditioned bursts
    wait_pin = 1'b1; clr(); send(8'h94); settle();
    chk(pulses == 0, "R9 met", pulses, 0);
    wait_pin = 1'b0; clr(); send(8'h94);
    repeat (9) @(negedge clk);
    wait_pin = 1'b1; settle();
    chk(pulses == 5 && sclk == 1'b0, "R9 high", pulses, 5);
    clr(); send(8'h95);
    repeat (5) @(negedge clk);
    wait_pin = 1'b0; settle();
    chk(pulses == 3, "R9 low", pulses, 3);

    // R10 count-or-pin
    wait_pin = 1'b0; clr(); send(8'h9C); send(8'h00); send(8'h00); settle();
    chk(pulses == 8, "R10 count", pulses, 8);
    wait_pin = 1'b1; clr(); send(8'h9C); send(8'h00); send(8'h00); settle();
    chk(pulses == 0, "R10 met", pulses, 0);
    clr(); send(8'h9D); send(8'h01); send(8'h00);
    repeat (7) @(negedge clk);
    wait_pin = 1'b0; settle();
    chk(pulses == 4, "R10 pin", pulses, 4);

    // R7 pin waits
    send(8'h88);
    repeat (20) @(negedge clk);
    chk(!cmd_ready, "R7 stall high", cmd_ready, 0);
    wait_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_ready, "R7 resume", cmd_ready, 1);
    send(8'h89);
    repeat (10) @(negedge clk);
    chk(!cmd_ready, "R7 stall low", cmd_ready, 0);
    wait_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk(cmd_ready, "R7 resume low", cmd_ready, 1);

    // R6 flush
    clr(); send(8'h87); send(8'h87); send(8'h81); settle();
    chk(fl == 2, "R6", fl, 2);

    // R12 unknown opcodes
    begin
      logic [15:0] po, pe;
      send(8'h80); send(8'h5C); send(8'hC3);
      settle();
      po = pin_out; pe = pin_oe;
      for (int o = 0; o < 256; o++) begin
        if (!known(o)) begin
          clr(); send(8'(o));
          repeat (3) @(negedge clk);
          chk(rn == 2 && rq[0] == 8'hFA && rq[1] == 8'(o), "R12",
              {rq[0], rq[1]}, {8'hFA, 8'(o)});
        end
      end
      chk(pin_out == po && pin_oe == pe && cmd_ready, "R12 state", {pin_out, pin_oe}, {po, pe});
    end

    // R11 open collector
    send(8'h80); send(8'hA4); send(8'hFF);
    send(8'h82); send(8'h0F); send(8'h3C);
    send(8'h9E); settle();
    chk(pin_oe == 16'h305B && pin_out == 16'h0FA4, "R11", pin_oe, 16'h305B);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule